// File: doc/BRIEF.md
# Lockstep Accumulator Array with Lane Masking

This block is a row of identical processing lanes. Each lane has one accumulator register and its own private data bank, and every lane carries out the same one-address instruction in the same cycle. A control unit outside the block supplies each instruction: an opcode, a row address, an index row for indexed loads, a source lane for broadcasts and an immediate value. Because every lane reaches only its own bank and all banks share one row address, a whole row of a distributed array moves in a single access.

A per-lane enable mask lets conditional code run as straight-line code. A test of every accumulator (zero, nonzero, positive or negative) yields one bit per lane that becomes the new mask. The control unit runs the "then" path under that mask and the "else" path under the complement. Loading all ones brings every lane back. Instructions take effect in issue order. The accumulators and the mask are visible on registered outputs.

Top module: `simd_array`

## Requirements
- R1: While `rst` is high, all accumulators become 0 and the mask becomes all ones.
- R2: Opcode 8 (load immediate) writes `op_imm` into the accumulator of every enabled lane. The result appears on `acc_out` after the second rising edge following issue.
- R3: Opcode 1 (load) sets each enabled lane's accumulator to word `op_row` of that lane's bank. Opcode 2 (indexed load) does the same with `op_index` as the row and ignores `op_row`.
- R4: Opcode 3 (store) writes each enabled lane's accumulator to word `op_row` of its own bank and leaves the accumulators unchanged. A load of that row issued in the very next cycle returns the stored value.
- R5: Opcodes 4, 5 and 6 replace the accumulator with acc+mem, acc-mem and acc*mem, using the word at `op_row`. Each result is the low 16 bits of the result, in two's complement.
- R6: Opcode 7 (broadcast) copies the accumulator of lane `bcast_src`, as it stood before the instruction, into every enabled lane.
- R7: A lane whose mask bit is 0 keeps both its accumulator and its bank contents through any opcode.
- R8: With `mask_load` high, mask bit k becomes `mask_value[k]`. The new mask appears on `mask_out` after the second rising edge and governs instructions issued from the next cycle on.
- R9: With `cmp_en` high, each mask bit becomes the result of testing that lane's accumulator. The test is chosen by `cmp_sel`: 0 = equal to zero, 1 = nonzero, 2 = greater than zero, 3 = less than zero. All lanes are tested whatever the current mask.
- R10: When `mask_load` and `cmp_en` are both high, `mask_value` wins. In any one issue cycle the opcode uses the mask held before that cycle, and the test uses the accumulators held before that cycle.
- R11: Opcode 0 and any code not listed leave accumulators, banks and mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Instruction opcode |
| op_row | input | ROW_AW | Row address for load, store and arithmetic |
| op_index | input | ROW_AW | Row used by indexed load |
| bcast_src | input | IDX_W | Source lane for broadcast |
| op_imm | input | DATA_W | Immediate value for load immediate |
| mask_load | input | 1 | Load the mask from `mask_value` |
| mask_value | input | NUM_PE | Mask bits, bit k for lane k |
| cmp_en | input | 1 | Replace the mask with a test of the accumulators |
| cmp_sel | input | 2 | Test choice (0 zero, 1 nonzero, 2 positive, 3 negative) |
| acc_out | output | NUM_PE*DATA_W | All accumulators, lane k at bits k*DATA_W upward |
| mask_out | output | NUM_PE | Current lane mask |

## Verification
Every instruction, mask load or test is sampled on the first rising edge and takes effect on the second, so its effect on `acc_out` and `mask_out` is due two edges after the issue cycle. The driver issues one instruction per cycle. It updates its own lane model and queues the expected outputs tagged with that due cycle, and the monitor compares them at the falling edge of exactly that cycle. Bank contents are seen only through later loads. This includes a load issued straight after a store to the same row, and loads that follow a store made under a partial mask.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_LD    = 4'd1,
    OP_LDX   = 4'd2,
    OP_ST    = 4'd3,
    OP_ADD   = 4'd4,
    OP_SUB   = 4'd5,
    OP_MUL   = 4'd6,
    OP_BCAST = 4'd7,
    OP_LDI   = 4'd8
  } op_e;

  typedef enum logic [1:0] {
    TST_ZERO = 2'd0,
    TST_NZ   = 2'd1,
    TST_POS  = 2'd2,
    TST_NEG  = 2'd3
  } tst_e;

endpackage

// File: rtl/simd_bank.sv
module simd_bank #(
  parameter int DATA_W = 16,
  parameter int ROWS   = 16,
  parameter int AW     = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [ROWS];

  // read-first single-clock RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ROWS   = 16,
  localparam int AW    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lane_en,
  input  op_e               op_q,
  input  logic [DATA_W-1:0] imm_q,
  input  logic [DATA_W-1:0] bval,
  input  logic [AW-1:0]     rd_row,
  input  logic [AW-1:0]     wr_row,
  output logic [DATA_W-1:0] acc_q
);

  logic              bank_we;
  logic [DATA_W-1:0] bank_rdata;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] acc_nxt;

  assign bank_we = (op_q == OP_ST) && lane_en;

  simd_bank #(.DATA_W(DATA_W), .ROWS(ROWS)) bank_i (
    .clk   (clk),
    .we    (bank_we),
    .waddr (wr_row),
    .wdata (acc_q),
    .raddr (rd_row),
    .rdata (bank_rdata)
  );

  // a read issued while a store to the same row retires sees the stored word
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit  <= 1'b0;
      fwd_data <= '0;
    end else begin
      fwd_hit  <= bank_we && (rd_row == wr_row);
      fwd_data <= acc_q;
    end
  end

  assign operand = fwd_hit ? fwd_data : bank_rdata;

  always_comb begin
    case (op_q)
      OP_LD, OP_LDX: acc_nxt = operand;
      OP_ADD:        acc_nxt = acc_q + operand;
      OP_SUB:        acc_nxt = acc_q - operand;
      OP_MUL:        acc_nxt = acc_q * operand;
      OP_BCAST:      acc_nxt = bval;
      OP_LDI:        acc_nxt = imm_q;
      default:       acc_nxt = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= '0;
    else if (lane_en) acc_q <= acc_nxt;
  end

  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !lane_en |=> acc_q == $past(acc_q)); // R7

  AST_LDI_VALUE: assert property (@(posedge clk) disable iff (rst)
    (lane_en && op_q == OP_LDI) |=> acc_q == $past(imm_q)); // R2

  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_NOP) |=> acc_q == $past(acc_q)); // R11

endmodule

// File: rtl/simd_mask.sv
module simd_mask
  import simd_pkg::*;
#(
  parameter int NUM_PE = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_q,
  input  logic [NUM_PE-1:0]        val_q,
  input  logic                     cmp_q,
  input  tst_e                     sel_q,
  input  logic [NUM_PE*DATA_W-1:0] acc_flat,
  output logic [NUM_PE-1:0]        mask_q
);

  logic [NUM_PE-1:0] tst_vec;
  logic [NUM_PE-1:0] sign_vec;

  always_comb begin
    for (int k = 0; k < NUM_PE; k++) begin
      logic [DATA_W-1:0] a;
      a = acc_flat[k*DATA_W +: DATA_W];
      case (sel_q)
        TST_ZERO: tst_vec[k] = (a == '0);
        TST_NZ:   tst_vec[k] = (a != '0);
        TST_POS:  tst_vec[k] = !a[DATA_W-1] && (a != '0);
        default:  tst_vec[k] = a[DATA_W-1];
      endcase
      sign_vec[k] = acc_flat[k*DATA_W + DATA_W - 1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '1;
    else if (ld_q)  mask_q <= val_q;
    else if (cmp_q) mask_q <= tst_vec;
  end

  AST_MASK_RESET: assert property (@(posedge clk)
    rst |=> mask_q == '1); // R1

  AST_MASK_PRIO: assert property (@(posedge clk) disable iff (rst)
    ld_q |=> mask_q == $past(val_q)); // R10

  AST_CMP_NEG: assert property (@(posedge clk) disable iff (rst)
    (cmp_q && !ld_q && sel_q == TST_NEG) |=> mask_q == $past(sign_vec)); // R9

endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int NUM_PE  = 8,
  parameter int DATA_W  = 16,
  parameter int ROWS    = 16,
  localparam int ROW_AW = $clog2(ROWS),
  localparam int IDX_W  = $clog2(NUM_PE)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [3:0]               op_code,
  input  logic [ROW_AW-1:0]        op_row,
  input  logic [ROW_AW-1:0]        op_index,
  input  logic [IDX_W-1:0]         bcast_src,
  input  logic [DATA_W-1:0]        op_imm,
  input  logic                     mask_load,
  input  logic [NUM_PE-1:0]        mask_value,
  input  logic                     cmp_en,
  input  logic [1:0]               cmp_sel,
  output logic [NUM_PE*DATA_W-1:0] acc_out,
  output logic [NUM_PE-1:0]        mask_out
);

  op_e               op_in;
  op_e               op_q;
  logic [ROW_AW-1:0] rd_row;
  logic [ROW_AW-1:0] row_q;
  logic [IDX_W-1:0]  bsrc_q;
  logic [DATA_W-1:0] imm_q;
  logic              ld_q;
  logic [NUM_PE-1:0] val_q;
  logic              cmp_q;
  tst_e              sel_q;
  logic [NUM_PE-1:0] mask_q;
  logic [DATA_W-1:0] acc_arr [NUM_PE];
  logic [NUM_PE*DATA_W-1:0] acc_flat;
  logic [DATA_W-1:0] bval;

  assign op_in  = op_e'(op_code);
  assign rd_row = (op_in == OP_LDX) ? op_index : op_row;

  // issue stage: bank reads start here, everything else retires next edge
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_NOP;
      row_q  <= '0;
      bsrc_q <= '0;
      imm_q  <= '0;
      ld_q   <= 1'b0;
      val_q  <= '0;
      cmp_q  <= 1'b0;
      sel_q  <= TST_ZERO;
    end else begin
      op_q   <= op_in;
      row_q  <= op_row;
      bsrc_q <= bcast_src;
      imm_q  <= op_imm;
      ld_q   <= mask_load;
      val_q  <= mask_value;
      cmp_q  <= cmp_en;
      sel_q  <= tst_e'(cmp_sel);
    end
  end

  assign bval = acc_arr[bsrc_q];

  for (genvar k = 0; k < NUM_PE; k++) begin : g_lane
    simd_pe #(.DATA_W(DATA_W), .ROWS(ROWS)) pe_i (
      .clk     (clk),
      .rst     (rst),
      .lane_en (mask_q[k]),
      .op_q    (op_q),
      .imm_q   (imm_q),
      .bval    (bval),
      .rd_row  (rd_row),
      .wr_row  (row_q),
      .acc_q   (acc_arr[k])
    );
    assign acc_flat[k*DATA_W +: DATA_W] = acc_arr[k];
  end

  simd_mask #(.NUM_PE(NUM_PE), .DATA_W(DATA_W)) mask_i (
    .clk      (clk),
    .rst      (rst),
    .ld_q     (ld_q),
    .val_q    (val_q),
    .cmp_q    (cmp_q),
    .sel_q    (sel_q),
    .acc_flat (acc_flat),
    .mask_q   (mask_q)
  );

  assign acc_out  = acc_flat;
  assign mask_out = mask_q;

  AST_BCAST_FILL: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_BCAST && mask_q == '1) |=> acc_flat == {NUM_PE{$past(bval)}}); // R6

  AST_STORE_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_ST) |=> acc_flat == $past(acc_flat)); // R4

endmodule

// File: tb/simd_array_tb_top.sv
`timescale 1ns/1ps
module simd_array_tb_top;
  import simd_pkg::*;

  localparam int NUM_PE = 8;
  localparam int DATA_W = 16;
  localparam int ROWS   = 16;
  localparam int ROW_AW = 4;
  localparam int IDX_W  = 3;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [3:0]               op_code = '0;
  logic [ROW_AW-1:0]        op_row = '0;
  logic [ROW_AW-1:0]        op_index = '0;
  logic [IDX_W-1:0]         bcast_src = '0;
  logic [DATA_W-1:0]        op_imm = '0;
  logic                     mask_load = 1'b0;
  logic [NUM_PE-1:0]        mask_value = '0;
  logic                     cmp_en = 1'b0;
  logic [1:0]               cmp_sel = '0;
  logic [NUM_PE*DATA_W-1:0] acc_out;
  logic [NUM_PE-1:0]        mask_out;

  always #2 clk = ~clk;

  simd_array #(.NUM_PE(NUM_PE), .DATA_W(DATA_W), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .op_row(op_row),
    .op_index(op_index), .bcast_src(bcast_src), .op_imm(op_imm),
    .mask_load(mask_load), .mask_value(mask_value), .cmp_en(cmp_en),
    .cmp_sel(cmp_sel), .acc_out(acc_out), .mask_out(mask_out)
  );

  typedef struct {
    int                       due;
    logic [NUM_PE*DATA_W-1:0] acc;
    logic [NUM_PE-1:0]        mask;
    string                    tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  logic [DATA_W-1:0] m_acc [NUM_PE];
  logic [DATA_W-1:0] m_mem [NUM_PE][ROWS];
  logic [NUM_PE-1:0] m_mask;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [NUM_PE*DATA_W-1:0] pack_acc();
    logic [NUM_PE*DATA_W-1:0] v;
    for (int k = 0; k < NUM_PE; k++) v[k*DATA_W +: DATA_W] = m_acc[k];
    return v;
  endfunction

  // monitor: compare queued expectations in their due cycle
  always @(negedge clk) begin
    exp_t e;
    if (sbq.size() > 0 && sbq[0].due == cyc) begin
      e = sbq.pop_front();
      checks++;
      if (acc_out !== e.acc) begin
        errors++;
        $display("FAIL %s acc got %h expected %h", e.tag, acc_out, e.acc);
      end
      checks++;
      if (mask_out !== e.mask) begin
        errors++;
        $display("FAIL %s mask got %b expected %b", e.tag, mask_out, e.mask);
      end
    end
  end

  // driver: issue one instruction, update the lane model, queue the result
  task automatic step(input op_e op = OP_NOP, input int row = 0, input int idx = 0,
                      input int src = 0, input logic [DATA_W-1:0] imm = '0,
                      input logic mld = 1'b0, input logic [NUM_PE-1:0] mval = '0,
                      input logic cen = 1'b0, input tst_e csel = TST_ZERO,
                      input string tag = "R11");
    logic [DATA_W-1:0] nacc [NUM_PE];
    logic [NUM_PE-1:0] nmask;
    exp_t e;
    @(negedge clk);
    op_code = op; op_row = ROW_AW'(row); op_index = ROW_AW'(idx);
    bcast_src = IDX_W'(src); op_imm = imm; mask_load = mld;
    mask_value = mval; cmp_en = cen; cmp_sel = csel;
    for (int k = 0; k < NUM_PE; k++) begin
      nacc[k] = m_acc[k];
      if (m_mask[k]) begin
        case (op)
          OP_LD:    nacc[k] = m_mem[k][row];
          OP_LDX:   nacc[k] = m_mem[k][idx];
          OP_ST:    m_mem[k][row] = m_acc[k];
          OP_ADD:   nacc[k] = m_acc[k] + m_mem[k][row];
          OP_SUB:   nacc[k] = m_acc[k] - m_mem[k][row];
          OP_MUL:   nacc[k] = m_acc[k] * m_mem[k][row];
          OP_BCAST: nacc[k] = m_acc[src];
          OP_LDI:   nacc[k] = imm;
          default:  ;
        endcase
      end
    end
    nmask = m_mask;
    if (mld) nmask = mval;
    else if (cen) begin
      for (int k = 0; k < NUM_PE; k++) begin
        case (csel)
          TST_ZERO: nmask[k] = (m_acc[k] == '0);
          TST_NZ:   nmask[k] = (m_acc[k] != '0);
          TST_POS:  nmask[k] = !m_acc[k][DATA_W-1] && (m_acc[k] != '0);
          default:  nmask[k] = m_acc[k][DATA_W-1];
        endcase
      end
    end
    for (int k = 0; k < NUM_PE; k++) m_acc[k] = nacc[k];
    m_mask = nmask;
    e.due = cyc + 2; e.acc = pack_acc(); e.mask = m_mask; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang, expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NUM_PE; k++) m_acc[k] = '0;
    m_mask = '1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state seen at the ports
    checks++;
    if (acc_out !== '0) begin
      errors++; $display("FAIL R1 acc got %h expected 0", acc_out);
    end
    checks++;
    if (mask_out !== '1) begin
      errors++; $display("FAIL R1 mask got %b expected all ones", mask_out);
    end

    step(.op(OP_LDI), .imm(16'd5), .tag("R2"));
    step(.op(OP_NOP), .tag("R11"));
    step(.op(op_e'(4'd13)), .tag("R11"));
    for (int k = 0; k < NUM_PE; k++) begin
      step(.mld(1'b1), .mval(NUM_PE'(1) << k), .tag("R8"));
      step(.op(OP_LDI), .imm(DATA_W'(k*4 - 8)), .tag("R7"));
    end
    step(.mld(1'b1), .mval('1), .tag("R8"));
    step(.op(OP_ST), .row(3), .tag("R4"));
    step(.op(OP_LDI), .imm(16'd1), .tag("R2"));
    step(.op(OP_LD), .row(3), .tag("R3"));
    step(.op(OP_ADD), .row(3), .tag("R5"));
    step(.op(OP_SUB), .row(3), .tag("R5"));
    step(.op(OP_MUL), .row(3), .tag("R5"));
    step(.op(OP_ST), .row(6), .tag("R4"));
    step(.op(OP_LD), .row(6), .tag("R4"));
    step(.op(OP_LDI), .imm(16'h7fff), .tag("R2"));
    step(.op(OP_ADD), .row(3), .tag("R5"));
    step(.op(OP_MUL), .row(6), .tag("R5"));
    step(.op(OP_LDX), .row(9), .idx(3), .tag("R3"));
    step(.op(OP_BCAST), .src(5), .tag("R6"));
    step(.op(OP_LD), .row(3), .tag("R3"));
    step(.mld(1'b1), .mval(8'hF0), .tag("R8"));
    step(.op(OP_BCAST), .src(1), .tag("R7"));
    step(.mld(1'b1), .mval(8'h0F), .tag("R8"));
    step(.cen(1'b1), .csel(TST_ZERO), .tag("R9"));
    step(.cen(1'b1), .csel(TST_NZ), .tag("R9"));
    step(.cen(1'b1), .csel(TST_POS), .tag("R9"));
    step(.cen(1'b1), .csel(TST_NEG), .tag("R9"));
    step(.op(OP_LDI), .imm(16'h1234), .tag("R7"));
    step(.mld(1'b1), .mval(8'h0F), .tag("R8"));
    step(.op(OP_ST), .row(3), .tag("R7"));
    step(.mld(1'b1), .mval('1), .tag("R8"));
    step(.op(OP_LD), .row(3), .tag("R7"));
    step(.op(OP_LDI), .imm(16'd9), .mld(1'b1), .mval(8'hA5),
         .cen(1'b1), .csel(TST_ZERO), .tag("R10"));
    step(.op(OP_LDI), .imm(16'd0), .tag("R10"));
    step(.tag("R11"));
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule